// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block sets the low-power state of a small microcontroller core. Software arms it with a sleep-enable bit and a 2-bit mode selection. A one-cycle sleep strobe from the core then moves it out of the active state into one of four sleep states: idle, ADC noise reduction, power-down or standby. In each state it drives clock enables for the CPU, flash, I/O and ADC domains, plus a run request for the oscillator. When the ADC is enabled, entering idle or ADC noise reduction also issues one conversion-start pulse.

While asleep, the controller samples a set of level wake inputs. Which ones are honoured depends on the state. The reset-class inputs (external pin, watchdog, brown-out) return the controller to active in every sleep state and raise a one-cycle reset request. The interrupt-class inputs return it to active without that request. A wake from standby passes through a fixed settling interval before the clocks come back. The current state is reported on a 3-bit code.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, stateCode is 0 (active), all four clock enables and oscRun are 1, and adcStart and resetReq are 0.
- R2: A sleep strobe while sleepEn is 0 has no effect; stateCode stays 0.
- R3: A strobe with modeSel = 3 while xtalSel is 0 is ignored and stateCode stays 0. With xtalSel = 1 the same strobe enters standby.
- R4: An accepted strobe in the active state moves stateCode, at the next clock edge, to modeSel + 1: 1 idle, 2 ADC noise reduction, 3 power-down, 4 standby.
- R5: The enables {cpuClkEn, flashClkEn, ioClkEn, adcClkEn, oscRun} are decoded from the state as follows: active 11111, idle 00111, ADC noise reduction 00011, power-down 00000, standby 00001, waking (code 5) 00001.
- R6: adcStart is a single-cycle pulse. It coincides with the first cycle in idle or ADC noise reduction and occurs only when adcEnabled was 1 at the accepted strobe. It is never raised for any other transition.
- R7: In idle, any of wakeAdcDone, wakeNvmReady, wakeExtLevel, wakePinChange or wakeOtherIrq returns the controller to active at the next edge.
- R8: In ADC noise reduction, wakeAdcDone, wakeNvmReady, wakeExtLevel and wakePinChange wake the controller. wakeOtherIrq alone has no effect.
- R9: In power-down and standby, only wakeExtLevel, wakePinChange and the reset-class inputs wake the controller. wakeAdcDone, wakeNvmReady and wakeOtherIrq have no effect.
- R10: An interrupt-class wake in standby puts the controller in the waking state (code 5) for exactly six cycles; it then returns to active.
- R11: Any bit of wakeRst in a sleep or waking state returns the controller to active at the next edge, with resetReq high for that one cycle. An interrupt-class wake leaves resetReq at 0.
- R12: A permitted wake input that is already high when the strobe is accepted ends the sleep after one cycle in the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepEn | input | 1 | Arms the sleep strobe |
| modeSel | input | 2 | Target sleep mode: 0 idle, 1 ADC noise reduction, 2 power-down, 3 standby |
| xtalSel | input | 1 | A crystal or resonator clock source is configured |
| adcEnabled | input | 1 | The ADC is enabled |
| sleepStrobe | input | 1 | One-cycle sleep instruction strobe |
| wakeRst | input | NUM_RST_SRC | Reset-class wake levels (external, watchdog, brown-out) |
| wakeAdcDone | input | 1 | ADC conversion complete |
| wakeNvmReady | input | 1 | Nonvolatile memory write ready |
| wakeExtLevel | input | 1 | Level interrupt on external interrupt 0 |
| wakePinChange | input | 1 | Pin-change interrupt |
| wakeOtherIrq | input | 1 | Any other interrupt, such as a timer overflow |
| cpuClkEn | output | 1 | CPU clock enable |
| flashClkEn | output | 1 | Flash clock enable |
| ioClkEn | output | 1 | I/O clock enable |
| adcClkEn | output | 1 | ADC clock enable |
| oscRun | output | 1 | Keep the oscillator running |
| adcStart | output | 1 | One-cycle conversion start request |
| resetReq | output | 1 | One-cycle reset request after a reset-class wake |
| stateCode | output | 3 | 0 active, 1 idle, 2 ADC noise reduction, 3 power-down, 4 standby, 5 waking |

## Verification
The properties assume that every input is synchronous to clk and free of unknowns. They also assume that modeSel, xtalSel and adcEnabled are sampled only in the cycle of the strobe. Strobes that arrive while the controller is asleep are expected to be ignored rather than excluded. The stimulus changes inputs only on the falling edge. It keeps the reset-class wake bits rare, so that long sleeps and full standby wake intervals take place. Directed sequences cover wakes that are already high at the strobe, standby with and without a crystal, and ignored sources in each mode.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ADCNR  = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_STBY   = 3'd4,
    ST_WAKING = 3'd5
  } pwrState_t;

  // one-cycle requests from control to datapath
  typedef struct packed {
    logic adcKick;
    logic rstWake;
  } ctrlStrobe_t;

  // qualified wake levels from datapath to control
  typedef struct packed {
    logic irq;
    logic rst;
  } wakeQual_t;
endpackage

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
#(
  parameter int WAKE_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepEn,
  input  logic [1:0]  modeSel,
  input  logic        xtalSel,
  input  logic        adcEnabled,
  input  logic        sleepStrobe,
  input  wakeQual_t   qual,
  output pwrState_t   state,
  output ctrlStrobe_t strobes
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYCLES - 1);

  pwrState_t        nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             accept;

  assign accept = sleepStrobe && sleepEn && !(modeSel == 2'b11 && !xtalSel);

  always_comb begin
    nextState       = state;
    cntNext         = cnt;
    strobes.adcKick = 1'b0;
    strobes.rstWake = 1'b0;
    case (state)
      ST_ACTIVE: begin
        if (accept) begin
          nextState       = pwrState_t'({1'b0, modeSel} + 3'd1);
          strobes.adcKick = adcEnabled && !modeSel[1];
        end
      end
      ST_IDLE, ST_ADCNR, ST_PDOWN: begin
        if (qual.rst) begin
          nextState       = ST_ACTIVE;
          strobes.rstWake = 1'b1;
        end else if (qual.irq) begin
          nextState = ST_ACTIVE;
        end
      end
      ST_STBY: begin
        if (qual.rst) begin
          nextState       = ST_ACTIVE;
          strobes.rstWake = 1'b1;
        end else if (qual.irq) begin
          nextState = ST_WAKING;
          cntNext   = CNT_LOAD;
        end
      end
      ST_WAKING: begin
        if (qual.rst) begin
          nextState       = ST_ACTIVE;
          strobes.rstWake = 1'b1;
        end else if (cnt == '0) begin
          nextState = ST_ACTIVE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
    end
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_RST_SRC = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pwrState_t              state,
  input  ctrlStrobe_t            strobes,
  input  logic [NUM_RST_SRC-1:0] wakeRst,
  input  logic                   wakeAdcDone,
  input  logic                   wakeNvmReady,
  input  logic                   wakeExtLevel,
  input  logic                   wakePinChange,
  input  logic                   wakeOtherIrq,
  output wakeQual_t              qual,
  output logic                   cpuClkEn,
  output logic                   flashClkEn,
  output logic                   ioClkEn,
  output logic                   adcClkEn,
  output logic                   oscRun,
  output logic                   adcStart,
  output logic                   resetReq
);
  localparam int NUM_IRQ = 5;
  localparam int NUM_EN  = 5;

  logic [NUM_IRQ-1:0] irqVec, irqMask;
  logic [NUM_EN-1:0]  enVec;

  // bit order: other, adcDone, nvmReady, extLevel, pinChange
  assign irqVec = {wakeOtherIrq, wakeAdcDone, wakeNvmReady, wakeExtLevel, wakePinChange};

  always_comb begin
    case (state)
      ST_IDLE:           irqMask = 5'b11111;
      ST_ADCNR:          irqMask = 5'b01111;
      ST_PDOWN, ST_STBY: irqMask = 5'b00011;
      default:           irqMask = 5'b00000;
    endcase
  end

  assign qual.irq = |(irqVec & irqMask);
  assign qual.rst = |wakeRst;

  // bit order: cpu, flash, io, adc, osc
  always_comb begin
    case (state)
      ST_ACTIVE:            enVec = 5'b11111;
      ST_IDLE:              enVec = 5'b00111;
      ST_ADCNR:             enVec = 5'b00011;
      ST_PDOWN:             enVec = 5'b00000;
      ST_STBY, ST_WAKING:   enVec = 5'b00001;
      default:              enVec = 5'b11111;
    endcase
  end

  assign {cpuClkEn, flashClkEn, ioClkEn, adcClkEn, oscRun} = enVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcStart <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      adcStart <= strobes.adcKick;
      resetReq <= strobes.rstWake;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_RST_SRC = 3,
  parameter int WAKE_CYCLES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sleepEn,
  input  logic [1:0]             modeSel,
  input  logic                   xtalSel,
  input  logic                   adcEnabled,
  input  logic                   sleepStrobe,
  input  logic [NUM_RST_SRC-1:0] wakeRst,
  input  logic                   wakeAdcDone,
  input  logic                   wakeNvmReady,
  input  logic                   wakeExtLevel,
  input  logic                   wakePinChange,
  input  logic                   wakeOtherIrq,
  output logic                   cpuClkEn,
  output logic                   flashClkEn,
  output logic                   ioClkEn,
  output logic                   adcClkEn,
  output logic                   oscRun,
  output logic                   adcStart,
  output logic                   resetReq,
  output logic [2:0]             stateCode
);
  pwrState_t   state;
  ctrlStrobe_t strobes;
  wakeQual_t   qual;

  swc_control #(.WAKE_CYCLES(WAKE_CYCLES)) ctrlInst (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .xtalSel(xtalSel), .adcEnabled(adcEnabled), .sleepStrobe(sleepStrobe),
    .qual(qual), .state(state), .strobes(strobes)
  );

  swc_datapath #(.NUM_RST_SRC(NUM_RST_SRC)) dpInst (
    .clk(clk), .rstN(rstN), .state(state), .strobes(strobes),
    .wakeRst(wakeRst), .wakeAdcDone(wakeAdcDone), .wakeNvmReady(wakeNvmReady),
    .wakeExtLevel(wakeExtLevel), .wakePinChange(wakePinChange),
    .wakeOtherIrq(wakeOtherIrq), .qual(qual),
    .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .ioClkEn(ioClkEn),
    .adcClkEn(adcClkEn), .oscRun(oscRun), .adcStart(adcStart), .resetReq(resetReq)
  );

  assign stateCode = state;
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk #(
  parameter int NUM_RST_SRC = 3,
  parameter int WAKE_CYCLES = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sleepEn,
  input logic [1:0]             modeSel,
  input logic                   xtalSel,
  input logic                   adcEnabled,
  input logic                   sleepStrobe,
  input logic [NUM_RST_SRC-1:0] wakeRst,
  input logic                   wakeAdcDone,
  input logic                   wakeNvmReady,
  input logic                   wakeExtLevel,
  input logic                   wakePinChange,
  input logic                   wakeOtherIrq,
  input logic                   cpuClkEn,
  input logic                   adcClkEn,
  input logic                   oscRun,
  input logic                   adcStart,
  input logic                   resetReq,
  input logic [2:0]             stateCode
);
  logic [31:0] wakingLen;

  always_ff @(posedge clk) begin
    if (!rstN) wakingLen <= '0;
    else if (stateCode == 3'd5) wakingLen <= wakingLen + 1;
    else wakingLen <= '0;
  end

  AST_SLEEP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && !sleepEn) |=> stateCode == 3'd0); // R2
  AST_STANDBY_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && modeSel == 2'b11 && !xtalSel) |=> stateCode == 3'd0); // R3
  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && sleepStrobe && sleepEn && !(modeSel == 2'b11 && !xtalSel))
    |=> stateCode == {1'b0, $past(modeSel)} + 3'd1); // R4
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 3'd0) |-> !cpuClkEn); // R5
  AST_PDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd3) |-> (!oscRun && !adcClkEn)); // R5
  AST_ADC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart); // R6
  AST_ADC_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> ((stateCode == 3'd1 || stateCode == 3'd2) && $past(adcEnabled))); // R6
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd1 && wakeOtherIrq) |=> stateCode == 3'd0); // R7
  AST_ADCNR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd2 && !(|wakeRst) && !wakeAdcDone && !wakeNvmReady &&
     !wakeExtLevel && !wakePinChange) |=> stateCode == 3'd2); // R8
  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd3 && !(|wakeRst) && !wakeExtLevel && !wakePinChange)
    |=> stateCode == 3'd3); // R9
  AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && $past(stateCode) == 3'd5 && !resetReq)
    |-> wakingLen == WAKE_CYCLES); // R10
  AST_RESET_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != 3'd0 && (|wakeRst)) |=> (stateCode == 3'd0 && resetReq)); // R11
  AST_RSTREQ_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> stateCode == 3'd0); // R11
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(
  .NUM_RST_SRC(NUM_RST_SRC), .WAKE_CYCLES(WAKE_CYCLES)
) chkInst (
  .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel), .xtalSel(xtalSel),
  .adcEnabled(adcEnabled), .sleepStrobe(sleepStrobe), .wakeRst(wakeRst),
  .wakeAdcDone(wakeAdcDone), .wakeNvmReady(wakeNvmReady), .wakeExtLevel(wakeExtLevel),
  .wakePinChange(wakePinChange), .wakeOtherIrq(wakeOtherIrq), .cpuClkEn(cpuClkEn),
  .adcClkEn(adcClkEn), .oscRun(oscRun), .adcStart(adcStart), .resetReq(resetReq),
  .stateCode(stateCode)
);

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int NRST = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepEn = 1'b0, xtalSel = 1'b0, adcEnabled = 1'b0, sleepStrobe = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [NRST-1:0] wakeRst = '0;
  logic wakeAdcDone = 1'b0, wakeNvmReady = 1'b0, wakeExtLevel = 1'b0;
  logic wakePinChange = 1'b0, wakeOtherIrq = 1'b0;
  logic cpuClkEn, flashClkEn, ioClkEn, adcClkEn, oscRun, adcStart, resetReq;
  logic [2:0] stateCode;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R4";

  int mState = 0;
  int mCnt = 0;
  bit mAdc = 1'b0;
  bit mRst = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_ctrl #(.NUM_RST_SRC(NRST), .WAKE_CYCLES(6)) uut (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel), .xtalSel(xtalSel),
    .adcEnabled(adcEnabled), .sleepStrobe(sleepStrobe), .wakeRst(wakeRst),
    .wakeAdcDone(wakeAdcDone), .wakeNvmReady(wakeNvmReady), .wakeExtLevel(wakeExtLevel),
    .wakePinChange(wakePinChange), .wakeOtherIrq(wakeOtherIrq),
    .cpuClkEn(cpuClkEn), .flashClkEn(flashClkEn), .ioClkEn(ioClkEn),
    .adcClkEn(adcClkEn), .oscRun(oscRun), .adcStart(adcStart), .resetReq(resetReq),
    .stateCode(stateCode)
  );

  // expected enables {cpu, flash, io, adc, osc} per state (R5)
  function automatic logic [4:0] expEn(int st);
    case (st)
      0: return 5'b11111;
      1: return 5'b00111;
      2: return 5'b00011;
      3: return 5'b00000;
      default: return 5'b00001;
    endcase
  endfunction

  // interrupt-class wake permitted in state st (R7, R8, R9)
  function automatic bit irqAllowed(int st);
    case (st)
      1: return wakeAdcDone | wakeNvmReady | wakeExtLevel | wakePinChange | wakeOtherIrq;
      2: return wakeAdcDone | wakeNvmReady | wakeExtLevel | wakePinChange;
      3, 4: return wakeExtLevel | wakePinChange;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mAdc = 0; mRst = 0;
    end else begin
      mAdc = 0; mRst = 0;
      case (mState)
        0: if (sleepStrobe && sleepEn && !(modeSel == 2'b11 && !xtalSel)) begin
             mState = int'(modeSel) + 1;
             mAdc = adcEnabled && (modeSel < 2);
           end
        1, 2, 3: if (|wakeRst) begin mState = 0; mRst = 1; end
                 else if (irqAllowed(mState)) mState = 0;
        4: if (|wakeRst) begin mState = 0; mRst = 1; end
           else if (irqAllowed(4)) begin mState = 5; mCnt = 5; end
        default: if (|wakeRst) begin mState = 0; mRst = 1; end
                 else if (mCnt == 0) mState = 0;
                 else mCnt = mCnt - 1;
      endcase
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(curTag, int'(stateCode), mState);
    check("R5", int'({cpuClkEn, flashClkEn, ioClkEn, adcClkEn, oscRun}), int'(expEn(mState)));
    check("R6", int'(adcStart), int'(mAdc));
    check("R11", int'(resetReq), int'(mRst));
  endtask

  task automatic clearWakes();
    wakeRst = '0; wakeAdcDone = 0; wakeNvmReady = 0;
    wakeExtLevel = 0; wakePinChange = 0; wakeOtherIrq = 0;
  endtask

  task automatic sleepCmd(logic [1:0] m, logic en, logic xt, logic adc);
    modeSel = m; sleepEn = en; xtalSel = xt; adcEnabled = adc; sleepStrobe = 1;
    tick();
    sleepStrobe = 0;
  endtask

  task automatic backToActive();
    clearWakes();
    wakeRst = 3'b001;
    tick();
    clearWakes();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int wakeLen;
    void'($urandom(32'h5EED1234));
    curTag = "R1";
    tick(); tick();
    check("R1", int'(stateCode), 0);
    rstN = 1;
    tick();

    curTag = "R2";
    sleepCmd(2'd2, 1'b0, 1'b0, 1'b0); tick();
    check("R2", int'(stateCode), 0);

    curTag = "R3";
    sleepCmd(2'd3, 1'b1, 1'b0, 1'b0); tick();
    check("R3", int'(stateCode), 0);
    sleepCmd(2'd3, 1'b1, 1'b1, 1'b0);
    check("R3", int'(stateCode), 4);

    curTag = "R9";
    wakeAdcDone = 1; wakeNvmReady = 1; wakeOtherIrq = 1;
    tick(); tick();
    check("R9", int'(stateCode), 4);
    clearWakes();

    curTag = "R10";
    wakePinChange = 1;
    tick();
    clearWakes();
    wakeLen = 1;
    while (stateCode == 3'd5 && wakeLen < 20) begin tick(); if (stateCode == 3'd5) wakeLen++; end
    check("R10", wakeLen, 6);
    check("R10", int'(stateCode), 0);

    curTag = "R8";
    sleepCmd(2'd1, 1'b1, 1'b0, 1'b1);
    check("R6", int'(adcStart), 1);
    wakeOtherIrq = 1;
    tick(); tick();
    check("R8", int'(stateCode), 2);
    wakeAdcDone = 1;
    tick();
    check("R8", int'(stateCode), 0);
    clearWakes();

    curTag = "R7";
    sleepCmd(2'd0, 1'b1, 1'b0, 1'b0);
    check("R4", int'(stateCode), 1);
    wakeOtherIrq = 1;
    tick();
    check("R7", int'(stateCode), 0);
    clearWakes();

    curTag = "R12";
    wakeExtLevel = 1;
    sleepCmd(2'd2, 1'b1, 1'b0, 1'b1);
    check("R12", int'(stateCode), 3);
    check("R6", int'(adcStart), 0);
    tick();
    check("R12", int'(stateCode), 0);
    clearWakes();

    curTag = "R11";
    sleepCmd(2'd2, 1'b1, 1'b0, 1'b0);
    wakeRst = 3'b100;
    tick();
    check("R11", int'(resetReq), 1);
    clearWakes();
    tick();
    check("R11", int'(resetReq), 0);
    backToActive();

    curTag = "R4 R7 R8 R9 R10 R11";
    for (int i = 0; i < 4000; i++) begin
      sleepEn = ($urandom % 8) != 0;
      modeSel = 2'($urandom % 4);
      xtalSel = 1'($urandom % 2);
      adcEnabled = 1'($urandom % 2);
      sleepStrobe = ($urandom % 4) == 0;
      wakeAdcDone = ($urandom % 10) == 0;
      wakeNvmReady = ($urandom % 12) == 0;
      wakeExtLevel = ($urandom % 14) == 0;
      wakePinChange = ($urandom % 14) == 0;
      wakeOtherIrq = ($urandom % 6) == 0;
      wakeRst = (($urandom % 40) == 0) ? NRST'(1 << ($urandom % NRST)) : '0;
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule